// File: doc/BRIEF.md
# In-band XON/XOFF flow controller

This block handles software (in-band) flow control for a serial port. It has a transmit half and a receive half. The transmit half watches the occupancy of the local receive FIFO. When the FIFO fills past a high mark, it asks the transmitter to insert a stop character. When the FIFO drains back to a low mark, it asks for a resume character. It can send one programmed character, or two programmed characters back to back as one sequence.

The receive half compares each incoming byte with the programmed stop and resume characters. It holds the local transmitter with `tx_pause` or releases it. Matched control bytes are removed from the byte stream passed onward, and every other byte is forwarded in arrival order. Serialization is not part of this block: the transmitter takes each inserted character through a request/acknowledge pair, ahead of its normal data at the next character boundary.

A single 4-bit mode field sets both halves. Bits [3:2] select the transmit behaviour and bits [1:0] select the receive behaviour. To change the field from one non-zero value to another, software must first write zero.

Top module: `soft_flow_ctl`

## Requirements
- R1: After reset the mode field is 0000, `tx_pause` is 0, `ins_req` is 0 and `fwd_valid` is 0.
- R2: A mode write is taken only when the stored field is 0000 or the written value is 0000. A write of a non-zero value over a non-zero value leaves the stored field unchanged.
- R3: Transmit select, mode bits [3:2]: 00 inserts nothing. 10 uses `on_a`/`off_a`. 01 uses `on_b`/`off_b`. 11 sends the A character and then the B character of the same kind in the next two character slots.
- R4: While transmit control is enabled, a FIFO level at or above HI_MARK triggers one stop sequence. No further stop sequence follows while the level stays high.
- R5: After a stop sequence, a FIFO level at or below LO_MARK triggers one resume sequence. Two resume sequences never occur without a stop sequence between them.
- R6: `ins_req` stays high with `ins_char` unchanged until `ins_ack` is seen. Each acknowledged cycle completes one character.
- R7: Receive select, mode bits [1:0]: 00 forwards every byte. 10 matches `on_a`/`off_a`. 01 matches `on_b`/`off_b`.
- R8: With receive select 11, `off_a` followed immediately by `off_b` pauses, and `on_a` followed immediately by `on_b` resumes. An A character followed by any other byte is forwarded, and then that byte is forwarded, in order.
- R9: A stop match sets `tx_pause` and a resume match clears it. Matched bytes are never forwarded. Receive select 00 clears `tx_pause`.
- R10: A byte that is not held back appears on `fwd_data` with `fwd_valid` in the cycle after `rx_valid`. Input bytes are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 4 | Mode value to write |
| on_a | input | 8 | Resume character A |
| on_b | input | 8 | Resume character B |
| off_a | input | 8 | Stop character A |
| off_b | input | 8 | Stop character B |
| rx_valid | input | 1 | Incoming byte strobe |
| rx_data | input | 8 | Incoming byte |
| rx_level | input | LVL_W | Local receive FIFO occupancy |
| fwd_valid | output | 1 | Forwarded byte strobe |
| fwd_data | output | 8 | Forwarded byte |
| ins_req | output | 1 | Request to insert a flow character |
| ins_char | output | 8 | Character to insert |
| ins_ack | input | 1 | Transmitter has taken the character |
| tx_pause | output | 1 | Hold the local transmitter |

## Verification
A wrong stop/resume memory in the transmit half shows up as an extra or missing character on `ins_char` within a cycle of the level crossing a mark. A sequence pointer that goes astray in dual mode shows up as a wrong or missing second character in the very next slot. In the receive half, a lost held byte or a lost replay byte shows up as a gap or reordering in the forwarded stream one or two cycles after the following input byte. A wrong pause decision is visible on `tx_pause` one cycle after the byte that completes the match.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    SEL_OFF  = 2'b00,
    SEL_B    = 2'b01,
    SEL_A    = 2'b10,
    SEL_BOTH = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'b00,
    TX_FIRST  = 2'b01,
    TX_SECOND = 2'b10
  } tx_st_e;

  function automatic logic mode_write_ok(input logic [3:0] cur, input logic [3:0] nxt);
    return (cur == 4'b0000) || (nxt == 4'b0000);
  endfunction

  function automatic logic [7:0] first_char(input sel_e sel, input logic stop,
      input logic [7:0] on_a, input logic [7:0] on_b,
      input logic [7:0] off_a, input logic [7:0] off_b);
    if (sel == SEL_B) return stop ? off_b : on_b;
    return stop ? off_a : on_a;
  endfunction
endpackage

// File: rtl/sfc_cfg_gate.sv
module sfc_cfg_gate (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr,
  input  logic [3:0] cfg_mode,
  output logic [3:0] mode_q
);
  import sfc_pkg::*;

  logic take_wr;
  assign take_wr = cfg_wr && mode_write_ok(mode_q, cfg_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 4'b0000;
    else if (take_wr) mode_q <= cfg_mode;
  end

  assert_keep_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && mode_q != 4'b0000 && cfg_mode != 4'b0000) |=> $stable(mode_q));
endmodule

// File: rtl/sfc_tx_insert.sv
module sfc_tx_insert #(
  parameter int LVL_W   = 7,
  parameter int HI_MARK = 48,
  parameter int LO_MARK = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sfc_pkg::sel_e    tx_sel,
  input  logic [7:0]       on_a,
  input  logic [7:0]       on_b,
  input  logic [7:0]       off_a,
  input  logic [7:0]       off_b,
  input  logic [LVL_W-1:0] rx_level,
  output logic             ins_req,
  output logic [7:0]       ins_char,
  input  logic             ins_ack
);
  import sfc_pkg::*;

  localparam logic [LVL_W-1:0] HI_L = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0] LO_L = LVL_W'(LO_MARK);

  tx_st_e st_q;
  sel_e   seq_sel_q;
  logic   seq_stop_q;
  logic   stop_sent_q;
  logic   need_stop, need_go, start_seq;

  assign need_stop = (tx_sel != SEL_OFF) && !stop_sent_q && (rx_level >= HI_L);
  assign need_go   = (tx_sel != SEL_OFF) &&  stop_sent_q && (rx_level <= LO_L);
  assign start_seq = (st_q == TX_IDLE) && (need_stop || need_go);

  assign ins_req  = (st_q != TX_IDLE);
  assign ins_char = (st_q == TX_SECOND) ? (seq_stop_q ? off_b : on_b)
                  : first_char(seq_sel_q, seq_stop_q, on_a, on_b, off_a, off_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= TX_IDLE;
      seq_sel_q   <= SEL_OFF;
      seq_stop_q  <= 1'b0;
      stop_sent_q <= 1'b0;
    end else begin
      case (st_q)
        TX_IDLE: begin
          if (start_seq) begin
            st_q        <= TX_FIRST;
            seq_sel_q   <= tx_sel;
            seq_stop_q  <= need_stop;
            stop_sent_q <= need_stop;
          end else if (tx_sel == SEL_OFF) begin
            stop_sent_q <= 1'b0;
          end
        end
        TX_FIRST:  if (ins_ack) st_q <= (seq_sel_q == SEL_BOTH) ? TX_SECOND : TX_IDLE;
        TX_SECOND: if (ins_ack) st_q <= TX_IDLE;
        default:   st_q <= TX_IDLE;
      endcase
    end
  end

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !ins_ack) |=> (ins_req && $stable(ins_char)));
  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel == SEL_OFF) |-> !start_seq);
  assert_dual_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TX_FIRST && ins_ack && seq_sel_q == SEL_BOTH) |=> (ins_req && st_q == TX_SECOND));
  assert_one_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_seq && need_stop) |=> stop_sent_q);
endmodule

// File: rtl/sfc_rx_match.sv
module sfc_rx_match (
  input  logic          clk,
  input  logic          rst_n,
  input  sfc_pkg::sel_e rx_sel,
  input  logic [7:0]    on_a,
  input  logic [7:0]    on_b,
  input  logic [7:0]    off_a,
  input  logic [7:0]    off_b,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  output logic          fwd_valid,
  output logic [7:0]    fwd_data,
  output logic          tx_pause
);
  import sfc_pkg::*;

  logic       held_v, held_stop;
  logic [7:0] held_b;
  logic       rp_v;
  logic [7:0] rp_b;

  logic [7:0] cmp_on, cmp_off;
  logic       is_on, is_off, single, dual;
  logic       pair_done, new_hold, single_hit, plain, stop_evt, go_evt;

  always_comb begin
    cmp_on     = (rx_sel == SEL_B) ? on_b : on_a;
    cmp_off    = (rx_sel == SEL_B) ? off_b : off_a;
    is_on      = (rx_data == cmp_on);
    is_off     = (rx_data == cmp_off);
    single     = (rx_sel == SEL_A) || (rx_sel == SEL_B);
    dual       = (rx_sel == SEL_BOTH);
    pair_done  = rx_valid && held_v && dual && (rx_data == (held_stop ? off_b : on_b));
    new_hold   = rx_valid && !pair_done && dual && (is_on || is_off);
    single_hit = rx_valid && single && (is_on || is_off);
    plain      = rx_valid && !pair_done && !new_hold && !single_hit;
    stop_evt   = (single_hit && is_off) || (pair_done && held_stop);
    go_evt     = (single_hit && !is_off) || (pair_done && !held_stop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_data  <= 8'h00;
      held_v    <= 1'b0;
      held_stop <= 1'b0;
      held_b    <= 8'h00;
      rp_v      <= 1'b0;
      rp_b      <= 8'h00;
      tx_pause  <= 1'b0;
    end else begin
      fwd_valid <= 1'b0;
      if (rx_valid) begin
        if (held_v && !pair_done) begin
          fwd_valid <= 1'b1;
          fwd_data  <= held_b;
          if (plain) begin
            rp_v <= 1'b1;
            rp_b <= rx_data;
          end
        end else if (plain) begin
          fwd_valid <= 1'b1;
          fwd_data  <= rx_data;
        end
        held_v <= new_hold;
        if (new_hold) begin
          held_b    <= rx_data;
          held_stop <= is_off;
        end
      end else if (rp_v) begin
        fwd_valid <= 1'b1;
        fwd_data  <= rp_b;
        rp_v      <= 1'b0;
      end
      if (rx_sel == SEL_OFF) tx_pause <= 1'b0;
      else if (stop_evt)     tx_pause <= 1'b1;
      else if (go_evt)       tx_pause <= 1'b0;
    end
  end

  assert_hit_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((single_hit && !held_v && !rp_v) || (pair_done && !rp_v)) |=> !fwd_valid);
  assert_pause_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_pause) |-> $past(stop_evt));
  assert_plain_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (plain && !held_v) |=> (fwd_valid && fwd_data == $past(rx_data)));
endmodule

// File: rtl/soft_flow_ctl.sv
module soft_flow_ctl #(
  parameter int LVL_W   = 7,
  parameter int HI_MARK = 48,
  parameter int LO_MARK = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [3:0]       cfg_mode,
  input  logic [7:0]       on_a,
  input  logic [7:0]       on_b,
  input  logic [7:0]       off_a,
  input  logic [7:0]       off_b,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [LVL_W-1:0] rx_level,
  output logic             fwd_valid,
  output logic [7:0]       fwd_data,
  output logic             ins_req,
  output logic [7:0]       ins_char,
  input  logic             ins_ack,
  output logic             tx_pause
);
  import sfc_pkg::*;

  logic [3:0] mode_q;
  sel_e       tx_sel, rx_sel;

  assign tx_sel = sel_e'(mode_q[3:2]);
  assign rx_sel = sel_e'(mode_q[1:0]);

  sfc_cfg_gate u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .mode_q(mode_q)
  );

  sfc_tx_insert #(.LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_sel(tx_sel),
    .on_a(on_a), .on_b(on_b), .off_a(off_a), .off_b(off_b),
    .rx_level(rx_level), .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack)
  );

  sfc_rx_match u_rx (
    .clk(clk), .rst_n(rst_n), .rx_sel(rx_sel),
    .on_a(on_a), .on_b(on_b), .off_a(off_a), .off_b(off_b),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .tx_pause(tx_pause)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |=> (!ins_req && !fwd_valid && !tx_pause));
endmodule

// File: tb/tb_soft_flow_ctl.sv
module tb_soft_flow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [3:0] cfg_mode = 4'h0;
  logic [7:0] on_a = 8'h11, on_b = 8'h91, off_a = 8'h13, off_b = 8'h93;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [6:0] rx_level = 7'd0;
  logic       fwd_valid, ins_req, ins_ack = 1'b0, tx_pause;
  logic [7:0] fwd_data, ins_char;

  int checks = 0, fails = 0, stall = 0;
  logic       waiting = 1'b0;
  logic [7:0] prev_c = 8'h00;
  logic [7:0] exp_tx[$];
  string      tag_tx[$];
  logic [7:0] exp_rx[$];
  string      tag_rx[$];

  always #4 clk = ~clk;

  soft_flow_ctl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .on_a(on_a), .on_b(on_b), .off_a(off_a), .off_b(off_b),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_level(rx_level),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .ins_req(ins_req), .ins_char(ins_char), .ins_ack(ins_ack), .tx_pause(tx_pause)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // transmitter model and insert monitor
  always @(negedge clk) begin
    if (!rst_n) ins_ack = 1'b0;
    else if (ins_ack) ins_ack = 1'b0;
    else if (ins_req) begin
      if (waiting) check("R6 held char", ins_char, prev_c);
      if (stall > 0) begin
        stall--;
        waiting = 1'b1;
        prev_c = ins_char;
      end else begin
        waiting = 1'b0;
        ins_ack = 1'b1;
        if (exp_tx.size() == 0) check("R4/R5 unexpected insert", ins_char, 8'hxx);
        else check(tag_tx.pop_front(), ins_char, exp_tx.pop_front());
      end
    end
  end

  // forwarded-stream monitor
  always @(negedge clk) begin
    if (rst_n && fwd_valid) begin
      if (exp_rx.size() == 0) check("R9 unexpected forward", fwd_data, 8'hxx);
      else check(tag_rx.pop_front(), fwd_data, exp_rx.pop_front());
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_mode(input logic [3:0] m);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_wr = 1'b0;
    wait_cyc(1);
  endtask

  task automatic set_level(input logic [6:0] v);
    @(negedge clk); rx_level = v;
    wait_cyc(10);
  endtask

  task automatic expect_tx(input logic [7:0] c, input string tag);
    exp_tx.push_back(c); tag_tx.push_back(tag);
  endtask

  task automatic expect_rx(input logic [7:0] c, input string tag);
    exp_rx.push_back(c); tag_rx.push_back(tag);
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
    wait_cyc(2);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check("R1 pause", {7'd0, tx_pause}, 8'd0);
    check("R1 req", {7'd0, ins_req}, 8'd0);
    check("R1 fwd", {7'd0, fwd_valid}, 8'd0);
    rst_n = 1'b1;
    wait_cyc(2);

    // mode 0000: nothing inserted, nothing matched (R3, R7)
    set_level(7'd60);
    expect_rx(8'h13, "R7 select 00 forwards");
    send(8'h13);
    check("R9 no pause in 00", {7'd0, tx_pause}, 8'd0);
    set_level(7'd0);

    // single A on both halves
    write_mode(4'b1010);
    expect_tx(8'h13, "R4 stop A");
    set_level(7'd60);
    set_level(7'd55);
    set_level(7'd30);
    expect_tx(8'h11, "R5 resume A");
    set_level(7'd10);
    set_level(7'd5);
    send(8'h13);
    check("R9 pause set", {7'd0, tx_pause}, 8'd1);
    expect_rx(8'h41, "R10 plain byte");
    send(8'h41);
    send(8'h11);
    check("R9 pause clear", {7'd0, tx_pause}, 8'd0);

    // non-zero to non-zero write ignored
    write_mode(4'b0101);
    expect_rx(8'h93, "R2 old receive select kept");
    send(8'h93);
    check("R2 no pause", {7'd0, tx_pause}, 8'd0);
    expect_tx(8'h13, "R2 old transmit select kept");
    set_level(7'd60);
    expect_tx(8'h11, "R2 resume A");
    set_level(7'd10);

    // single B, with a stalled transmitter
    write_mode(4'b0000);
    write_mode(4'b0101);
    stall = 3;
    expect_tx(8'h93, "R3 stop B");
    set_level(7'd60);
    expect_tx(8'h91, "R3 resume B");
    set_level(7'd5);
    send(8'h93);
    check("R7 select 01 pause", {7'd0, tx_pause}, 8'd1);
    expect_rx(8'h13, "R7 A byte forwarded in 01");
    send(8'h13);
    send(8'h91);
    check("R7 select 01 resume", {7'd0, tx_pause}, 8'd0);
    send(8'h93);
    write_mode(4'b0000);
    check("R9 select 00 clears pause", {7'd0, tx_pause}, 8'd0);

    // dual sequences
    write_mode(4'b1111);
    expect_tx(8'h13, "R3 dual stop first");
    expect_tx(8'h93, "R6 dual stop second");
    set_level(7'd60);
    expect_tx(8'h11, "R3 dual resume first");
    expect_tx(8'h91, "R6 dual resume second");
    set_level(7'd5);
    send(8'h13);
    send(8'h93);
    check("R8 dual pause", {7'd0, tx_pause}, 8'd1);
    expect_rx(8'h11, "R8 broken pair first");
    expect_rx(8'h55, "R8 broken pair second");
    send(8'h11);
    send(8'h55);
    check("R8 still paused", {7'd0, tx_pause}, 8'd1);
    send(8'h11);
    send(8'h91);
    check("R8 dual resume", {7'd0, tx_pause}, 8'd0);
    wait_cyc(5);

    check("R4/R5 inserts all seen", 8'(exp_tx.size()), 8'd0);
    check("R10 forwards all seen", 8'(exp_rx.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule